// File: doc/BRIEF.md
# USB Device Token Handshake Selector

This block picks the reply that a full-speed USB device endpoint gives to each decoded token. Each cycle it may receive one token, described by its kind (IN, OUT, SETUP), the endpoint's transfer type and the endpoint's control inputs. One cycle later it drives a registered result. The result is a handshake code (ACK, NAK or STALL) with a valid strobe, or a drop strobe that means the token was discarded without any reply. It also drives two interrupt pulses: one when the endpoint has been shut down, and one when a control data stage sees more tokens than its SETUP announced.

Two state machines and a decision stage hold the behaviour. The endpoint machine has the states EP_OFF, EP_LIVE and EP_DRAIN. An enable pulse moves it EP_OFF→EP_LIVE. A disable request on an IN endpoint moves it EP_LIVE→EP_DRAIN. Once the update window is clear it moves EP_DRAIN→EP_OFF and raises the disable interrupt. The endpoint machine also holds the halt (STALL) flag.

The window machine has the states WIN_IDLE and WIN_HOLD. An accepted isochronous OUT moves it WIN_IDLE→WIN_HOLD and loads a down-counter. It returns WIN_HOLD→WIN_IDLE when the counter reaches its final count. The window length is `BUSY_LEN = ceil(BUSY_PHY / CLK_RATIO)` cycles, where `CLK_RATIO` is the register clock to PHY clock ratio. The defaults give 7 cycles.

Top module: `tok_hs_sel`

## Requirements
- R1: Encodings: tok_kind IN=0, OUT=1, SETUP=2; ep_type CONTROL=0, ISO=1, BULK=2, INTERRUPT=3; hs_code ACK=0, NAK=1, STALL=2. For an IN or OUT token on an enabled non-isochronous endpoint outside the window, the reply in the next cycle is STALL whenever the halt flag is set, even when nak_bit is also high.
- R2: With no halt flag and no overrun, that reply is NAK when nak_bit is high and ACK when it is low.
- R3: An isochronous token outside the window gets no handshake and no drop strobe.
- R4: An isochronous OUT on an enabled endpoint opens a window of exactly BUSY_LEN cycles, starting in the cycle after the token.
- R5: A non-isochronous IN or OUT token inside the window is answered with NAK, whatever the halt flag and enable state.
- R6: An isochronous or SETUP token inside the window raises tok_drop for one cycle with hs_vld low, and does not extend the window.
- R7: ep_dis_req on an enabled endpoint with ep_is_in high disables the endpoint at once. dis_irq then pulses for one cycle, two cycles after the request when the window is idle. On an OUT endpoint (ep_is_in low) the request is ignored.
- R8: On a control endpoint with ctl_dstage high and ctl_left zero, an IN or OUT token raises ovr_irq in the next cycle. The reply is NAK while the halt flag is clear and STALL once it is set.
- R9: A stall_clr pulse returns the endpoint to ACK/NAK replies on the next token.
- R10: A SETUP token on an enabled control endpoint outside the window is always ACKed, even when halted, and it clears the halt flag. If stall_set arrives in the same cycle, the SETUP wins.
- R11: A token to a disabled endpoint outside the window gets no handshake and no drop strobe.
- R12: After reset all outputs are low, the endpoint is disabled, the halt flag is clear and the window is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_vld | input | 1 | A decoded token is present this cycle |
| tok_kind | input | 2 | Token kind: IN=0, OUT=1, SETUP=2 |
| ep_type | input | 2 | Transfer type: CONTROL=0, ISO=1, BULK=2, INTERRUPT=3 |
| ep_is_in | input | 1 | Endpoint direction is IN |
| ep_en_set | input | 1 | Pulse that enables the endpoint |
| ep_dis_req | input | 1 | Pulse requesting an IN endpoint shutdown |
| stall_set | input | 1 | Pulse that sets the halt flag |
| stall_clr | input | 1 | Pulse that clears the halt flag |
| nak_bit | input | 1 | Endpoint asks for NAK replies |
| ctl_dstage | input | 1 | A control data stage is in progress |
| ctl_left | input | CNT_W | Bytes still owed by the control data stage |
| hs_vld | output | 1 | hs_code is valid this cycle |
| hs_code | output | 2 | Handshake to send: ACK=0, NAK=1, STALL=2 |
| tok_drop | output | 1 | Token discarded without any reply |
| dis_irq | output | 1 | One-cycle pulse: endpoint has stopped |
| ovr_irq | output | 1 | One-cycle pulse: control data stage overrun |

## Verification
The bench probes both edges of the update window. It sends a bulk token in the last busy cycle and another in the first free cycle; a counter that is off by one would give an ACK too early or a NAK too late. It also sends an isochronous OUT inside the window: a design that reloads the counter would stretch the window, and a design that replies to it would break the drop rule. Further cases pair STALL with NAK, send a SETUP to a halted control endpoint and make a data-stage overrun happen before and after the halt flag is set. A wrong priority in any of these shows up as the wrong handshake code or a missing interrupt pulse.

// File: rtl/tok_hs_pkg.sv
package tok_hs_pkg;

    typedef enum logic [1:0] {
        TK_IN    = 2'd0,
        TK_OUT   = 2'd1,
        TK_SETUP = 2'd2,
        TK_RSVD  = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        EPT_CTRL = 2'd0,
        EPT_ISO  = 2'd1,
        EPT_BULK = 2'd2,
        EPT_INTR = 2'd3
    } ep_type_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_RSVD  = 2'd3
    } hs_code_e;

    typedef enum logic [1:0] {
        EP_OFF   = 2'd0,
        EP_LIVE  = 2'd1,
        EP_DRAIN = 2'd2
    } ep_state_e;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_HOLD = 1'b1
    } win_state_e;

endpackage

// File: rtl/iso_busy_win.sv
module iso_busy_win
    import tok_hs_pkg::*;
#(
    parameter int BUSY_LEN = 7,
    parameter int CW       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    win_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WIN_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            WIN_IDLE: begin
                if (load) begin
                    st_d  = WIN_HOLD;
                    cnt_d = CW'(BUSY_LEN);
                end
            end
            WIN_HOLD: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == CW'(1)) st_d = WIN_IDLE;
            end
            default: st_d = WIN_IDLE;
        endcase
    end

    assign busy = (st_q == WIN_HOLD);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(BUSY_LEN));

    // R6
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != CW'(1)) |=> (busy && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ep_state_fsm.sv
module ep_state_fsm
    import tok_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic dis_req,
    input  logic is_in,
    input  logic win_busy,
    input  logic stall_set,
    input  logic stall_clr,
    input  logic setup_acc,
    output logic ep_en,
    output logic halted,
    output logic dis_irq
);
    ep_state_e st_q, st_d;
    logic      irq_d, irq_q;
    logic      halt_q, halt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= EP_OFF;
            irq_q  <= 1'b0;
            halt_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            irq_q  <= irq_d;
            halt_q <= halt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        irq_d = 1'b0;
        unique case (st_q)
            EP_OFF:   if (en_set) st_d = EP_LIVE;
            EP_LIVE:  if (dis_req && is_in) st_d = EP_DRAIN;
            EP_DRAIN: begin
                if (!win_busy) begin
                    st_d  = EP_OFF;
                    irq_d = 1'b1;
                end
            end
            default:  st_d = EP_OFF;
        endcase
    end

    always_comb begin
        halt_d = halt_q;
        if (setup_acc)      halt_d = 1'b0;
        else if (stall_set) halt_d = 1'b1;
        else if (stall_clr) halt_d = 1'b0;
    end

    assign ep_en   = (st_q == EP_LIVE);
    assign halted  = halt_q;
    assign dis_irq = irq_q;

    // R10
    setup_clears_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_acc |=> !halted);

    // R7
    dis_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_irq |=> !dis_irq);

    // R7
    dis_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_en && dis_req && is_in) |=> !ep_en);

endmodule

// File: rtl/hs_decide.sv
module hs_decide
    import tok_hs_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_vld,
    input  logic [1:0]       tok_kind,
    input  logic [1:0]       ep_type,
    input  logic             nak_bit,
    input  logic             ctl_dstage,
    input  logic [CNT_W-1:0] ctl_left,
    input  logic             ep_en,
    input  logic             halted,
    input  logic             win_busy,
    output logic             win_load,
    output logic             setup_acc,
    output logic             hs_vld,
    output logic [1:0]       hs_code,
    output logic             tok_drop,
    output logic             ovr_irq
);
    tok_kind_e kind;
    ep_type_e  etype;
    hs_code_e  code_d, code_q;
    logic      vld_d, drop_d, ovr_d, overrun;

    assign kind  = tok_kind_e'(tok_kind);
    assign etype = ep_type_e'(ep_type);
    assign overrun = (etype == EPT_CTRL) && ctl_dstage && (ctl_left == '0);

    always_comb begin
        vld_d     = 1'b0;
        code_d    = HS_ACK;
        drop_d    = 1'b0;
        ovr_d     = 1'b0;
        win_load  = 1'b0;
        setup_acc = 1'b0;
        if (tok_vld) begin
            if (win_busy) begin
                if (etype == EPT_ISO || kind == TK_SETUP) begin
                    drop_d = 1'b1;
                end else begin
                    vld_d  = 1'b1;
                    code_d = HS_NAK;
                end
            end else if (ep_en) begin
                if (etype == EPT_ISO) begin
                    win_load = (kind == TK_OUT);
                end else if (kind == TK_SETUP) begin
                    if (etype == EPT_CTRL) begin
                        vld_d     = 1'b1;
                        code_d    = HS_ACK;
                        setup_acc = 1'b1;
                    end
                end else begin
                    vld_d = 1'b1;
                    ovr_d = overrun;
                    if (halted)                 code_d = HS_STALL;
                    else if (nak_bit || overrun) code_d = HS_NAK;
                    else                        code_d = HS_ACK;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_vld   <= 1'b0;
            code_q   <= HS_ACK;
            tok_drop <= 1'b0;
            ovr_irq  <= 1'b0;
        end else begin
            hs_vld   <= vld_d;
            code_q   <= code_d;
            tok_drop <= drop_d;
            ovr_irq  <= ovr_d;
        end
    end

    assign hs_code = code_q;

    // R1
    stall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_vld && !win_busy && ep_en && ep_type != 2'd1 && tok_kind != 2'd2 && halted)
        |=> (hs_vld && hs_code == 2'd2));

    // R3
    iso_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_vld && ep_type == 2'd1) |=> !hs_vld);

    // R5
    busy_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_vld && win_busy && (ep_type == 2'd2 || ep_type == 2'd3))
        |=> (hs_vld && hs_code == 2'd1));

    // R6
    drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_drop |-> !hs_vld);

    // R11
    off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_vld && !win_busy && !ep_en) |=> (!hs_vld && !tok_drop));

endmodule

// File: rtl/tok_hs_sel.sv
module tok_hs_sel
    import tok_hs_pkg::*;
#(
    parameter int BUSY_PHY  = 7,
    parameter int CLK_RATIO = 1,
    parameter int CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_vld,
    input  logic [1:0]       tok_kind,
    input  logic [1:0]       ep_type,
    input  logic             ep_is_in,
    input  logic             ep_en_set,
    input  logic             ep_dis_req,
    input  logic             stall_set,
    input  logic             stall_clr,
    input  logic             nak_bit,
    input  logic             ctl_dstage,
    input  logic [CNT_W-1:0] ctl_left,
    output logic             hs_vld,
    output logic [1:0]       hs_code,
    output logic             tok_drop,
    output logic             dis_irq,
    output logic             ovr_irq
);
    localparam int BUSY_LEN = (BUSY_PHY + CLK_RATIO - 1) / CLK_RATIO;
    localparam int WIN_CW   = $clog2(BUSY_LEN + 1);

    logic win_busy, win_load, setup_acc, ep_en, halted;

    iso_busy_win #(
        .BUSY_LEN (BUSY_LEN),
        .CW       (WIN_CW)
    ) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (win_load),
        .busy  (win_busy)
    );

    ep_state_fsm u_ep (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set    (ep_en_set),
        .dis_req   (ep_dis_req),
        .is_in     (ep_is_in),
        .win_busy  (win_busy),
        .stall_set (stall_set),
        .stall_clr (stall_clr),
        .setup_acc (setup_acc),
        .ep_en     (ep_en),
        .halted    (halted),
        .dis_irq   (dis_irq)
    );

    hs_decide #(
        .CNT_W (CNT_W)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_vld    (tok_vld),
        .tok_kind   (tok_kind),
        .ep_type    (ep_type),
        .nak_bit    (nak_bit),
        .ctl_dstage (ctl_dstage),
        .ctl_left   (ctl_left),
        .ep_en      (ep_en),
        .halted     (halted),
        .win_busy   (win_busy),
        .win_load   (win_load),
        .setup_acc  (setup_acc),
        .hs_vld     (hs_vld),
        .hs_code    (hs_code),
        .tok_drop   (tok_drop),
        .ovr_irq    (ovr_irq)
    );

endmodule

// File: tb/sim_tok_hs_sel.sv
module sim_tok_hs_sel;
    localparam int CNT_W = 10;
    localparam logic [1:0] K_IN = 2'd0, K_OUT = 2'd1, K_SETUP = 2'd2;
    localparam logic [1:0] T_CTRL = 2'd0, T_ISO = 2'd1, T_BULK = 2'd2, T_INTR = 2'd3;
    localparam logic [1:0] C_ACK = 2'd0, C_NAK = 2'd1, C_STALL = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_vld = 1'b0, ep_is_in = 1'b1, ep_en_set = 1'b0, ep_dis_req = 1'b0;
    logic stall_set = 1'b0, stall_clr = 1'b0, nak_bit = 1'b0, ctl_dstage = 1'b0;
    logic [1:0] tok_kind = 2'd0, ep_type = 2'd0;
    logic [CNT_W-1:0] ctl_left = '0;
    logic hs_vld, tok_drop, dis_irq, ovr_irq;
    logic [1:0] hs_code;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic       vld;
        logic [1:0] code;
        logic       drop;
        logic       ovr;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tok_hs_sel u0 (
        .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_kind(tok_kind),
        .ep_type(ep_type), .ep_is_in(ep_is_in), .ep_en_set(ep_en_set),
        .ep_dis_req(ep_dis_req), .stall_set(stall_set), .stall_clr(stall_clr),
        .nak_bit(nak_bit), .ctl_dstage(ctl_dstage), .ctl_left(ctl_left),
        .hs_vld(hs_vld), .hs_code(hs_code), .tok_drop(tok_drop),
        .dis_irq(dis_irq), .ovr_irq(ovr_irq)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b (vld,code,drop / irq)", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when a result is due
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, {hs_vld, (hs_vld ? hs_code : 2'b00), tok_drop},
                         {e.vld, (e.vld ? e.code : 2'b00), e.drop});
            check({e.req, " ovr"}, {3'b000, ovr_irq}, {3'b000, e.ovr});
        end
    end

    task automatic tok(input logic [1:0] k, input logic [1:0] t, input logic v,
                       input logic [1:0] c, input logic d, input logic o, input string req);
        exp_t e;
        tok_vld = 1'b1; tok_kind = k; ep_type = t;
        e.due = cyc + 1; e.vld = v; e.code = c; e.drop = d; e.ovr = o; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        tok_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_en();
        ep_en_set = 1'b1; @(negedge clk); ep_en_set = 1'b0;
    endtask

    task automatic pulse_stall(input bit set);
        if (set) stall_set = 1'b1; else stall_clr = 1'b1;
        @(negedge clk);
        stall_set = 1'b0; stall_clr = 1'b0;
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", {hs_vld, hs_code, tok_drop}, 4'b0000);
        check("R12 irq", {2'b00, dis_irq, ovr_irq}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: disabled endpoint stays silent
        tok(K_IN, T_BULK, 1'b0, C_ACK, 1'b0, 1'b0, "R11");
        pulse_en();

        // R2: plain ACK / NAK
        tok(K_IN, T_BULK, 1'b1, C_ACK, 1'b0, 1'b0, "R2 ack");
        nak_bit = 1'b1;
        tok(K_OUT, T_INTR, 1'b1, C_NAK, 1'b0, 1'b0, "R2 nak");
        // R1: STALL beats NAK
        pulse_stall(1'b1);
        tok(K_IN, T_BULK, 1'b1, C_STALL, 1'b0, 1'b0, "R1");
        // R9: clear returns to NAK, then ACK
        pulse_stall(1'b0);
        tok(K_IN, T_BULK, 1'b1, C_NAK, 1'b0, 1'b0, "R9");
        nak_bit = 1'b0;
        tok(K_OUT, T_BULK, 1'b1, C_ACK, 1'b0, 1'b0, "R9 ack");

        // R10: SETUP accepted while halted, halt cleared
        pulse_stall(1'b1);
        tok(K_SETUP, T_CTRL, 1'b1, C_ACK, 1'b0, 1'b0, "R10 setup");
        tok(K_IN, T_CTRL, 1'b1, C_ACK, 1'b0, 1'b0, "R10 halt cleared");

        // R8: control data stage overrun
        ctl_dstage = 1'b1; ctl_left = 10'd4;
        tok(K_IN, T_CTRL, 1'b1, C_ACK, 1'b0, 1'b0, "R8 bytes left");
        ctl_left = '0;
        tok(K_IN, T_CTRL, 1'b1, C_NAK, 1'b0, 1'b1, "R8 overrun nak");
        pulse_stall(1'b1);
        tok(K_OUT, T_CTRL, 1'b1, C_STALL, 1'b0, 1'b1, "R8 overrun stall");
        pulse_stall(1'b0);
        ctl_dstage = 1'b0;

        // R3: iso outside window silent
        tok(K_IN, T_ISO, 1'b0, C_ACK, 1'b0, 1'b0, "R3");

        // R4/R5/R6: window after iso OUT (7 cycles)
        tok(K_OUT, T_ISO, 1'b0, C_ACK, 1'b0, 1'b0, "R3 iso out");
        tok(K_IN, T_BULK, 1'b1, C_NAK, 1'b0, 1'b0, "R5 first busy");
        tok(K_SETUP, T_CTRL, 1'b0, C_ACK, 1'b1, 1'b0, "R6 setup drop");
        tok(K_OUT, T_ISO, 1'b0, C_ACK, 1'b1, 1'b0, "R6 iso drop");
        idle(3);
        tok(K_OUT, T_INTR, 1'b1, C_NAK, 1'b0, 1'b0, "R4 last busy");
        tok(K_OUT, T_INTR, 1'b1, C_ACK, 1'b0, 1'b0, "R4 first free");

        // R7: OUT endpoint ignores disable
        ep_is_in = 1'b0;
        ep_dis_req = 1'b1; @(negedge clk); ep_dis_req = 1'b0;
        check("R7 ignored irq", {3'b000, dis_irq}, 4'b0000);
        tok(K_IN, T_BULK, 1'b1, C_ACK, 1'b0, 1'b0, "R7 still live");
        // R7: IN endpoint disable
        ep_is_in = 1'b1;
        ep_dis_req = 1'b1; @(negedge clk); ep_dis_req = 1'b0;
        check("R7 draining", {3'b000, dis_irq}, 4'b0000);
        @(negedge clk);
        check("R7 irq", {3'b000, dis_irq}, 4'b0001);
        @(negedge clk);
        check("R7 irq pulse", {3'b000, dis_irq}, 4'b0000);
        tok(K_IN, T_BULK, 1'b0, C_ACK, 1'b0, 1'b0, "R7 R11 off");

        idle(3);
        if (sb.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule